// File: doc/BRIEF.md
# Sub-word Access Bridge for Word-Only Data Memory

This block lets a CPU load/store port issue byte, halfword and word accesses to a data memory that can only read or write whole, aligned 32-bit words and has no byte enables. The CPU gives a byte address. The bridge drives the word part of that address onto a 16-bit memory address bus and keeps the two low bits as the lane selector. Sub-word loads fetch the containing word, pick out the selected lane, move it to the low end of the result, and then zero-extend or sign-extend it. Sub-word stores read the containing word, replace only the selected lane, and write the merged word back to the same address. This read-merge-write is not atomic, which is acceptable because only one master uses the memory. The bridge serves data accesses only.

The CPU side is a valid/ready request channel. The CPU raises `req_valid` with its address, size, sign flag, direction and write data. It must keep all of them stable until it samples `req_ready` high on a rising clock edge, which is the transfer point. Back-pressure comes only from `req_ready`, which the bridge raises in the last cycle of the access. Load data and the error flag are valid only in that cycle. The memory returns read data one cycle after the cycle in which `mem_rd` is high.

Top module: `subword_bridge`

## Requirements
- R1: Every memory operation is a full 32-bit read or write. `mem_rd` and `mem_wr` are never high together. Whenever either is high, `mem_addr` equals `req_addr[17:2]`.
- R2: A word load (`req_size` = 2'b10, `req_write` = 0) performs one read and completes in its second cycle with the whole word. The low two address bits are ignored.
- R3: A word store (`req_size` = 2'b10) writes `req_wdata` in the cycle it is presented and completes in that cycle, without any read.
- R4: A byte load (`req_size` = 2'b00) returns lane k, where k = `req_addr[1:0]`, taken from memory data bits [8k+7:8k] and right-aligned in `rd_data`.
- R5: A halfword load (`req_size` = 2'b01) returns bits [15:0] when `req_addr[1]` = 0 and bits [31:16] when it is 1, right-aligned in `rd_data`.
- R6: When `req_signed` = 1, a sub-word load copies the top bit of the lane (bit 7 or bit 15) into all higher bits. When it is 0, the higher bits are zero.
- R7: A byte or halfword store reads the word, then writes back to the same address a word in which only the selected lane holds the low bits of `req_wdata`. All other lanes keep their old value. It performs exactly one read and one write.
- R8: A sub-word store completes in its third cycle, with its write in that cycle. Every load completes in its second cycle.
- R9: A halfword request with `req_addr[0]` = 1, or a request with `req_size` = 2'b11, completes in its first cycle with `acc_err` = 1. It performs no memory read or write. `acc_err` is high only together with `req_ready`.
- R10: `req_ready` is high only while `req_valid` is high. With no request pending, the bridge issues no memory operation.
- R11: While `rst_n` is low, `req_ready`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request completes at this edge |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend sub-word load data |
| req_addr | input | 18 | CPU byte address |
| req_wdata | input | 32 | Store data; sub-word stores use the low bits |
| rd_data | output | 32 | Load result, valid with `req_ready` |
| acc_err | output | 1 | Rejected request, valid with `req_ready` |
| mem_addr | output | 16 | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_rd` |

## Verification
On every cycle, the assertions check these protocol rules:
- reads and writes never overlap;
- a request held without ready stays stable;
- rejected requests never touch memory;
- load completion follows a read by one cycle;
- a sub-word store writes the same word it read two cycles before.

Only the bench's scenarios can show the data behaviour and the per-request latency. The data behaviour covers lane selection for every byte and halfword position, sign versus zero extension on lanes with the top bit set and clear, and whether a merged store leaves its neighbouring lanes intact. The bench checks the neighbouring lanes by reading the word back through later loads.

// File: rtl/subword_bridge_pkg.sv
`timescale 1ns/1ps
package subword_bridge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MERGE,
    ST_WRITE
  } state_e;

  typedef enum logic [1:0] {
    AC_WORD,
    AC_SUB,
    AC_BAD
  } acc_e;

  // Sort a request into the path the controller takes for it.
  function automatic acc_e classify(input logic [1:0] size, input logic lsb0);
    acc_e r;
    case (size)
      SZ_BYTE: r = AC_SUB;
      SZ_HALF: r = lsb0 ? AC_BAD : AC_SUB;
      SZ_WORD: r = AC_WORD;
      default: r = AC_BAD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/subword_bridge_ctrl.sv
`timescale 1ns/1ps
module subword_bridge_ctrl
  import subword_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  acc_e acc,
  output logic mem_rd,
  output logic mem_wr,
  output logic req_ready,
  output logic acc_err,
  output logic use_merged,
  output logic capture
);

  state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    mem_rd     = 1'b0;
    mem_wr     = 1'b0;
    req_ready  = 1'b0;
    acc_err    = 1'b0;
    use_merged = 1'b0;
    capture    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          case (acc)
            AC_BAD: begin
              req_ready = 1'b1;
              acc_err   = 1'b1;
            end
            AC_WORD: begin
              if (req_write) begin
                mem_wr    = 1'b1;
                req_ready = 1'b1;
              end else begin
                mem_rd  = 1'b1;
                state_d = ST_READ;
              end
            end
            default: begin
              mem_rd  = 1'b1;
              state_d = req_write ? ST_MERGE : ST_READ;
            end
          endcase
        end
      end
      ST_READ: begin
        // read data is on mem_rdata now; finish the load
        req_ready = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_MERGE: begin
        capture = 1'b1;
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        mem_wr     = 1'b1;
        use_merged = 1'b1;
        req_ready  = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/subword_bridge_extract.sv
`timescale 1ns/1ps
module subword_bridge_extract
  import subword_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LSB_W  = 2
) (
  input  logic [DATA_W-1:0] word,
  input  logic [LSB_W-1:0]  lsb,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [DATA_W-1:0] result
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] byte_lane;
  logic [HALF_W-1:0] half_lane;
  logic              byte_top, half_top;

  assign byte_lane = word[{lsb, 3'b000} +: BYTE_W];
  assign half_lane = word[{lsb[LSB_W-1:1], 4'b0000} +: HALF_W];
  assign byte_top  = sgn & byte_lane[BYTE_W-1];
  assign half_top  = sgn & half_lane[HALF_W-1];

  always_comb begin
    case (size)
      SZ_BYTE: result = {{(DATA_W-BYTE_W){byte_top}}, byte_lane};
      SZ_HALF: result = {{(DATA_W-HALF_W){half_top}}, half_lane};
      default: result = word;
    endcase
  end

endmodule

// File: rtl/subword_bridge_merge.sv
`timescale 1ns/1ps
module subword_bridge_merge
  import subword_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LSB_W  = 2
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LSB_W-1:0]  lsb,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] merged
);

  localparam int NLANES = DATA_W / 8;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic       hit;
    logic [7:0] fresh;
    always_comb begin
      case (size)
        SZ_BYTE: begin
          hit   = (lsb == LSB_W'(g));
          fresh = wdata[7:0];
        end
        SZ_HALF: begin
          hit   = (lsb[LSB_W-1:1] == (LSB_W-1)'(g / 2));
          fresh = wdata[8*(g%2) +: 8];
        end
        default: begin
          hit   = 1'b1;
          fresh = wdata[8*g +: 8];
        end
      endcase
    end
    assign merged[8*g +: 8] = hit ? fresh : old_word[8*g +: 8];
  end

endmodule

// File: rtl/subword_bridge.sv
`timescale 1ns/1ps
module subword_bridge
  import subword_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LSB_W   = $clog2(DATA_W / 8),
  localparam int BADDR_W = ADDR_W + LSB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic               req_signed,
  input  logic [BADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic               acc_err,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);

  acc_e              acc;
  logic              use_merged, capture;
  logic [LSB_W-1:0]  lane_sel;
  logic [DATA_W-1:0] merged, merged_q;

  assign lane_sel = req_addr[LSB_W-1:0];
  assign mem_addr = req_addr[BADDR_W-1:LSB_W];
  assign acc      = classify(req_size, req_addr[0]);

  subword_bridge_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .acc        (acc),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .req_ready  (req_ready),
    .acc_err    (acc_err),
    .use_merged (use_merged),
    .capture    (capture)
  );

  subword_bridge_extract #(.DATA_W(DATA_W), .LSB_W(LSB_W)) u_extract (
    .word   (mem_rdata),
    .lsb    (lane_sel),
    .size   (req_size),
    .sgn    (req_signed),
    .result (rd_data)
  );

  subword_bridge_merge #(.DATA_W(DATA_W), .LSB_W(LSB_W)) u_merge (
    .old_word (mem_rdata),
    .wdata    (req_wdata),
    .lsb      (lane_sel),
    .size     (req_size),
    .merged   (merged)
  );

  // Hold the merged word for the write cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       merged_q <= '0;
    else if (capture) merged_q <= merged;
  end

  assign mem_wdata = use_merged ? merged_q : req_wdata;

endmodule

// File: rtl/subword_bridge_chk.sv
`timescale 1ns/1ps
module subword_bridge_chk #(
  parameter int ADDR_W  = 16,
  parameter int BADDR_W = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [1:0]         req_size,
  input logic [BADDR_W-1:0] req_addr,
  input logic               acc_err,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               mem_rd,
  input logic               mem_wr
);

  logic sub_store;
  assign sub_store = req_write && (req_size == 2'b00 || req_size == 2'b01);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R1

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_size)); // R10

  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> req_ready); // R9

  AST_ERR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !mem_rd && !mem_wr); // R9

  AST_WORD_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_size == 2'b10 |-> req_ready && mem_wr && !mem_rd); // R3

  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_write && !acc_err |-> $past(mem_rd) && !mem_rd && !mem_wr); // R2

  AST_SUB_STORE_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && sub_store |-> $past(mem_rd, 2) && !$past(mem_rd) && !$past(mem_wr)); // R7

  AST_SUB_STORE_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && sub_store |-> mem_addr == $past(mem_addr, 2)); // R7

  AST_SUB_STORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && sub_store |-> req_ready); // R8

endmodule

bind subword_bridge subword_bridge_chk #(.ADDR_W(ADDR_W), .BADDR_W(BADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .acc_err   (acc_err),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr)
);

// File: tb/subword_bridge_test.sv
`timescale 1ns/1ps
module subword_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic        req_signed = 1'b0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        acc_err;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  subword_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_signed(req_signed),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .acc_err(acc_err), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Word-only memory model with one-cycle read latency.
  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic check_eq(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  typedef struct {
    string       tag;
    logic        is_load;
    logic [31:0] data;
    logic        err;
    int          lat;
    int          nrd;
    int          nwr;
    logic [31:0] wword;
  } exp_t;

  exp_t exp_q[$];

  // Driver: predicts the outcome, queues it, then drives the request.
  task automatic access(input logic wr, input logic [1:0] sz, input logic sg,
                        input logic [17:0] a, input logic [31:0] wd, input string tag);
    exp_t e;
    logic [31:0] old, nw;
    logic [7:0]  b;
    logic [15:0] h;
    int idx;
    idx = int'(a[9:2]);
    old = ref_mem[idx];
    e.tag = tag; e.is_load = 1'b0; e.data = '0; e.err = 1'b0;
    e.lat = 1; e.nrd = 0; e.nwr = 0; e.wword = '0;
    if (sz == 2'b11 || (sz == 2'b01 && a[0])) begin
      e.err = 1'b1;
    end else if (!wr) begin
      e.is_load = 1'b1; e.lat = 2; e.nrd = 1;
      case (a[1:0])
        2'd0: b = old[7:0];
        2'd1: b = old[15:8];
        2'd2: b = old[23:16];
        default: b = old[31:24];
      endcase
      h = a[1] ? old[31:16] : old[15:0];
      if (sz == 2'b00)      e.data = sg ? {{24{b[7]}}, b} : {24'h0, b};
      else if (sz == 2'b01) e.data = sg ? {{16{h[15]}}, h} : {16'h0, h};
      else                  e.data = old;
    end else begin
      e.nwr = 1;
      if (sz == 2'b10) begin
        nw = wd;
      end else begin
        e.lat = 3; e.nrd = 1; nw = old;
        if (sz == 2'b00) begin
          case (a[1:0])
            2'd0: nw[7:0]   = wd[7:0];
            2'd1: nw[15:8]  = wd[7:0];
            2'd2: nw[23:16] = wd[7:0];
            default: nw[31:24] = wd[7:0];
          endcase
        end else if (a[1]) nw[31:16] = wd[15:0];
        else               nw[15:0]  = wd[15:0];
      end
      e.wword = nw;
      ref_mem[idx] = nw;
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = wd;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Monitor: counts cycles and memory operations per request, compares on completion.
  int cyc_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] wr_seen = '0;
  always begin
    @(negedge clk);
    #2;
    if (rst_n && req_valid) begin
      cyc_cnt++;
      if (mem_rd || mem_wr)
        check_eq("R1 memory word address", {16'h0, mem_addr}, {16'h0, req_addr[17:2]});
      if (mem_rd) rd_cnt++;
      if (mem_wr) begin
        wr_cnt++;
        wr_seen = mem_wdata;
      end
      if (req_ready) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R10 unexpected completion: actual 1 expected 0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check_eq({e.tag, " latency R8"}, 32'(cyc_cnt), 32'(e.lat));
          check_eq({e.tag, " error flag R9"}, {31'h0, acc_err}, {31'h0, e.err});
          check_eq({e.tag, " read count"}, 32'(rd_cnt), 32'(e.nrd));
          check_eq({e.tag, " write count"}, 32'(wr_cnt), 32'(e.nwr));
          if (e.is_load) check_eq({e.tag, " load data"}, rd_data, e.data);
          if (e.nwr > 0) check_eq({e.tag, " written word"}, wr_seen, e.wword);
        end
        cyc_cnt = 0; rd_cnt = 0; wr_cnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = {8'(i * 7 + 8'h81), 8'(i * 3 + 8'h12), 8'(8'hF0 - i), 8'(i + 8'h6C)};
      ref_mem[i] = mem[i];
    end
    mem[5] = 32'h8A7F_F10C; ref_mem[5] = 32'h8A7F_F10C;
    mem[6] = 32'h7FFE_8001; ref_mem[6] = 32'h7FFE_8001;

    repeat (3) @(negedge clk);
    #2;
    check_eq("R11 ready low in reset", {31'h0, req_ready}, 32'h0);
    check_eq("R11 no memory op in reset", {30'h0, mem_rd, mem_wr}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    access(1'b0, 2'b10, 1'b0, {8'h00, 8'd4, 2'b00}, 32'h0, "R2 word load");
    access(1'b0, 2'b10, 1'b0, {8'h5A, 8'd4, 2'b11}, 32'h0, "R1/R2 word load low bits ignored");
    for (int lane = 0; lane < 4; lane++) begin
      access(1'b0, 2'b00, 1'b0, {8'h00, 8'd5, 2'(lane)}, 32'h0, "R4/R6 byte load unsigned");
      access(1'b0, 2'b00, 1'b1, {8'h03, 8'd5, 2'(lane)}, 32'h0, "R4/R6 byte load signed");
    end
    for (int hl = 0; hl < 2; hl++) begin
      for (int sg = 0; sg < 2; sg++) begin
        access(1'b0, 2'b01, 1'(sg), {8'h01, 8'd5, 1'(hl), 1'b0}, 32'h0, "R5/R6 half load lane5");
        access(1'b0, 2'b01, 1'(sg), {8'h01, 8'd6, 1'(hl), 1'b0}, 32'h0, "R5/R6 half load lane6");
      end
    end
    access(1'b1, 2'b10, 1'b0, {8'hC3, 8'd8, 2'b00}, 32'hDEAD_BEEF, "R1/R3 word store");
    access(1'b0, 2'b10, 1'b0, {8'hC3, 8'd8, 2'b00}, 32'h0, "R3 word store readback");
    for (int lane = 0; lane < 4; lane++) begin
      access(1'b1, 2'b00, 1'b0, {8'h22, 8'd9, 2'(lane)}, 32'hFFFF_FF00 | 32'(8'h31 + lane),
             "R7 byte store");
      access(1'b0, 2'b10, 1'b0, {8'h22, 8'd9, 2'b00}, 32'h0, "R7 byte store readback");
    end
    access(1'b1, 2'b01, 1'b0, {8'h07, 8'd10, 2'b10}, 32'h1234_ABCD, "R7 half store upper");
    access(1'b0, 2'b10, 1'b0, {8'h07, 8'd10, 2'b00}, 32'h0, "R7 half store upper readback");
    access(1'b1, 2'b01, 1'b0, {8'h07, 8'd10, 2'b00}, 32'hFFFF_5E6F, "R7 half store lower");
    access(1'b0, 2'b10, 1'b0, {8'h07, 8'd10, 2'b00}, 32'h0, "R7 half store lower readback");
    access(1'b1, 2'b01, 1'b0, {8'h00, 8'd11, 2'b01}, 32'h5555_5555, "R9 misaligned half store");
    access(1'b1, 2'b11, 1'b0, {8'h00, 8'd11, 2'b00}, 32'h6666_6666, "R9 reserved size store");
    access(1'b0, 2'b11, 1'b0, {8'h00, 8'd11, 2'b00}, 32'h0, "R9 reserved size load");
    access(1'b0, 2'b01, 1'b1, {8'h00, 8'd11, 2'b11}, 32'h0, "R9 misaligned half load");
    access(1'b0, 2'b10, 1'b0, {8'h00, 8'd11, 2'b00}, 32'h0, "R9 word unchanged after rejects");

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #2;
      check_eq("R10 idle ready low", {31'h0, req_ready}, 32'h0);
      check_eq("R10 idle no memory op", {30'h0, mem_rd, mem_wr}, 32'h0);
    end
    check_eq("R10 all requests completed", 32'(exp_q.size()), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule